// File: doc/BRIEF.md
# Banked GPIO Port with Edge Interrupts

This block is a register-mapped general-purpose I/O port. Its pins are grouped into byte-wide banks (three banks of eight by default, 24 pins in total). A byte-wide register bus sets pin directions, raises or lowers output levels through separate write-one set and write-one clear registers, and reads back the live, synchronized pin levels.

Every input passes through a two-flop synchronizer and is then compared with its value one clock earlier. A transition is logged in a per-pin edge register when its polarity (rising, falling, or both) is enabled for that pin. The same event also sets a per-pin status bit if that pin's interrupt enable is on. Both registers are cleared by writing ones to them. The single active-low interrupt output stays low while any status bit is set.

Registers occupy groups of four addresses. Group g starts at address 4*g. Within a group, the most significant bank sits at offset 0 and bank 0 sits at offset NUM_BANKS-1. An incrementing burst therefore returns banks from most to least significant. Groups: 0 level monitor (read-only), 1 direction, 2 set (write-only), 3 clear (write-only), 4 rising enable, 5 falling enable, 6 interrupt enable, 7 edge (write-one-to-clear), 8 status (write-one-to-clear).

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every register reads zero and all pins are inputs. Writing a direction byte makes a pin an output (pin_oe bit 1) where the bit is 1 and an input where it is 0.
- R2: Writing a byte to the set group drives the named output bits high. Writing a byte to the clear group drives them low. Zero bits in either write leave pin_out unchanged.
- R3: A read of the monitor group returns the synchronized level of every pin in the bank, whatever its direction.
- R4: A change on pin_in reaches the synchronized level two clocks later. The resulting edge bit reads as set from the clock after that.
- R5: Rising and falling detection are enabled per pin and independently. With both enabled, either transition is logged. With neither enabled, nothing is logged.
- R6: The edge register logs every enabled transition, whether or not the interrupt enable for that pin is set.
- R7: A status bit sets only for an enabled transition on a pin whose interrupt enable is 1.
- R8: Writing 1 to an edge or status bit clears it. Writing 0 leaves it unchanged.
- R9: When a new event and a clear of the same bit fall in the same clock, the bit ends up set.
- R10: irq_n is low exactly while at least one status bit is set.
- R11: Within each group, offset 0 holds the most significant bank and offset NUM_BANKS-1 holds bank 0 (pins 0..7).
- R12: bus_rdata is updated one clock after a read strobe and holds until the next read. Unmapped addresses and the write-only set and clear groups read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | BANK_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | BANK_W | Read data, registered |
| pin_in | input | NUM_BANKS*BANK_W | Pad input levels |
| pin_out | output | NUM_BANKS*BANK_W | Output levels |
| pin_oe | output | NUM_BANKS*BANK_W | Output enables (direction) |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
The bench uses the default build: three banks of eight pins. This places the most significant bank at offset 0, bank 1 in the middle and bank 0 at offset 2, so the reversed bank ordering is visible on every register group. A behavioural model tracks the synchronizer, the edge and status bits and all writes clock by clock. Directed phases cover set/clear, mixed rise/fall enables, and pins that toggle every cycle while clears are written, which catches set-versus-clear collisions. A long randomized phase then mixes pin activity with bus traffic to all mapped and unmapped addresses.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W        = 8;
  localparam int BANK_SEL_BITS = 2;   // four addresses per group
  localparam int GRP_COUNT     = 9;

  typedef enum logic [3:0] {
    GRP_MON  = 4'd0,
    GRP_DIR  = 4'd1,
    GRP_SET  = 4'd2,
    GRP_CLR  = 4'd3,
    GRP_RISE = 4'd4,
    GRP_FALL = 4'd5,
    GRP_IEN  = 4'd6,
    GRP_EDGE = 4'd7,
    GRP_STAT = 4'd8,
    GRP_NONE = 4'd15
  } reg_grp_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output reg_grp_e             grp_o,
  output logic [NUM_BANKS-1:0] bank_sel_o
);
  localparam int IDX_W = ADDR_W - BANK_SEL_BITS;

  logic [IDX_W-1:0]         grp_idx;
  logic [BANK_SEL_BITS-1:0] bank_off;
  logic                     mapped;

  assign grp_idx  = addr_i[ADDR_W-1:BANK_SEL_BITS];
  assign bank_off = addr_i[BANK_SEL_BITS-1:0];
  assign mapped   = (int'(grp_idx) < GRP_COUNT) && (int'(bank_off) < NUM_BANKS);

  // most significant bank sits at the lowest offset of each group
  always_comb begin
    grp_o = mapped ? reg_grp_e'(grp_idx[3:0]) : GRP_NONE;
    for (int b = 0; b < NUM_BANKS; b++) begin
      bank_sel_o[b] = mapped && (int'(bank_off) == (NUM_BANKS - 1 - b));
    end
  end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] prev_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] level_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      level_q <= '0;
      prev_q  <= '0;
    end else begin
      meta_q  <= pin_i;
      level_q <= meta_q;
      prev_q  <= level_q;
    end
  end

  assign level_o = level_q;
  assign prev_o  = prev_q;
  assign rise_o  = level_q & ~prev_q;
  assign fall_o  = ~level_q & prev_q;
endmodule

// File: rtl/gpio_event_regs.sv
module gpio_event_regs #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] rise_i,
  input  logic [NUM_BANKS*BANK_W-1:0] fall_i,
  input  logic [NUM_BANKS*BANK_W-1:0] rise_en_i,
  input  logic [NUM_BANKS*BANK_W-1:0] fall_en_i,
  input  logic [NUM_BANKS*BANK_W-1:0] irq_en_i,
  input  logic [NUM_BANKS*BANK_W-1:0] edge_clr_i,
  input  logic [NUM_BANKS*BANK_W-1:0] stat_clr_i,
  output logic [NUM_BANKS*BANK_W-1:0] hit_o,
  output logic [NUM_BANKS*BANK_W-1:0] edge_o,
  output logic [NUM_BANKS*BANK_W-1:0] stat_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;

    logic [BANK_W-1:0] hit;
    logic [BANK_W-1:0] edge_q, edge_d;
    logic [BANK_W-1:0] stat_q, stat_d;
    logic              edge_en, stat_en;

    always_comb begin
      hit     = (rise_i[LO +: BANK_W] & rise_en_i[LO +: BANK_W])
              | (fall_i[LO +: BANK_W] & fall_en_i[LO +: BANK_W]);
      // a fresh event outranks a clear in the same cycle
      edge_d  = (edge_q & ~edge_clr_i[LO +: BANK_W]) | hit;
      stat_d  = (stat_q & ~stat_clr_i[LO +: BANK_W]) | (hit & irq_en_i[LO +: BANK_W]);
      edge_en = (|hit) | (|edge_clr_i[LO +: BANK_W]);
      stat_en = (|hit) | (|stat_clr_i[LO +: BANK_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        edge_q <= '0;
        stat_q <= '0;
      end else begin
        if (edge_en) edge_q <= edge_d;
        if (stat_en) stat_q <= stat_d;
      end
    end

    assign hit_o[LO +: BANK_W]  = hit;
    assign edge_o[LO +: BANK_W] = edge_q;
    assign stat_o[LO +: BANK_W] = stat_q;
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BANK_W-1:0]           bus_wdata,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  output logic [BANK_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
  output logic [NUM_BANKS*BANK_W-1:0] pin_out,
  output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
  output logic                        irq_n
);
  localparam int NPINS = NUM_BANKS * BANK_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  reg_grp_e             grp;
  logic [NUM_BANKS-1:0] bank_sel;

  gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_i     (bus_addr),
    .grp_o      (grp),
    .bank_sel_o (bank_sel)
  );

  logic [NPINS-1:0] pin_sync, pin_prev, rise_ev, fall_ev;

  gpio_pin_sync #(.WIDTH(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .pin_i   (pin_in),
    .level_o (pin_sync),
    .prev_o  (pin_prev),
    .rise_o  (rise_ev),
    .fall_o  (fall_ev)
  );

  logic [NPINS-1:0] dir_q, dir_d;
  logic [NPINS-1:0] out_q, out_d;
  logic [NPINS-1:0] re_q, re_d;
  logic [NPINS-1:0] fe_q, fe_d;
  logic [NPINS-1:0] ie_q, ie_d;
  logic [NPINS-1:0] edge_clr, stat_clr;
  logic [NPINS-1:0] edge_q, stat_q, edge_hit;

  always_comb begin
    dir_d    = dir_q;
    out_d    = out_q;
    re_d     = re_q;
    fe_d     = fe_q;
    ie_d     = ie_q;
    edge_clr = '0;
    stat_clr = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_wr && bank_sel[b]) begin
        unique case (grp)
          GRP_DIR:  dir_d[b*BANK_W +: BANK_W]    = bus_wdata;
          GRP_SET:  out_d[b*BANK_W +: BANK_W]    = out_q[b*BANK_W +: BANK_W] | bus_wdata;
          GRP_CLR:  out_d[b*BANK_W +: BANK_W]    = out_q[b*BANK_W +: BANK_W] & ~bus_wdata;
          GRP_RISE: re_d[b*BANK_W +: BANK_W]     = bus_wdata;
          GRP_FALL: fe_d[b*BANK_W +: BANK_W]     = bus_wdata;
          GRP_IEN:  ie_d[b*BANK_W +: BANK_W]     = bus_wdata;
          GRP_EDGE: edge_clr[b*BANK_W +: BANK_W] = bus_wdata;
          GRP_STAT: stat_clr[b*BANK_W +: BANK_W] = bus_wdata;
          default:  ;
        endcase
      end
    end
  end

  logic cfg_en;
  assign cfg_en = bus_wr && (|bank_sel);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dir_q <= '0;
      out_q <= '0;
      re_q  <= '0;
      fe_q  <= '0;
      ie_q  <= '0;
    end else if (cfg_en) begin
      dir_q <= dir_d;
      out_q <= out_d;
      re_q  <= re_d;
      fe_q  <= fe_d;
      ie_q  <= ie_d;
    end
  end

  gpio_event_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_evt (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .rise_i     (rise_ev),
    .fall_i     (fall_ev),
    .rise_en_i  (re_q),
    .fall_en_i  (fe_q),
    .irq_en_i   (ie_q),
    .edge_clr_i (edge_clr),
    .stat_clr_i (stat_clr),
    .hit_o      (edge_hit),
    .edge_o     (edge_q),
    .stat_o     (stat_q)
  );

  logic [BANK_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rdata_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel[b]) begin
        unique case (grp)
          GRP_MON:  rdata_d = pin_sync[b*BANK_W +: BANK_W];
          GRP_DIR:  rdata_d = dir_q[b*BANK_W +: BANK_W];
          GRP_RISE: rdata_d = re_q[b*BANK_W +: BANK_W];
          GRP_FALL: rdata_d = fe_q[b*BANK_W +: BANK_W];
          GRP_IEN:  rdata_d = ie_q[b*BANK_W +: BANK_W];
          GRP_EDGE: rdata_d = edge_q[b*BANK_W +: BANK_W];
          GRP_STAT: rdata_d = stat_q[b*BANK_W +: BANK_W];
          default:  rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;
  assign irq_n     = ~(|stat_q);
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [BANK_W-1:0]           bus_wdata,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [BANK_W-1:0]           bus_rdata,
  input logic [NUM_BANKS*BANK_W-1:0] pin_out,
  input logic [NUM_BANKS*BANK_W-1:0] pin_oe,
  input logic                        irq_n,
  input logic [NUM_BANKS*BANK_W-1:0] pin_sync,
  input logic [NUM_BANKS*BANK_W-1:0] pin_prev,
  input logic [NUM_BANKS*BANK_W-1:0] edge_q,
  input logic [NUM_BANKS*BANK_W-1:0] edge_hit,
  input logic [NUM_BANKS*BANK_W-1:0] ie_q
);
  localparam logic [ADDR_W-1:0] DIR_B0  = ADDR_W'(4 * 1 + NUM_BANKS - 1);
  localparam logic [ADDR_W-1:0] SET_B0  = ADDR_W'(4 * 2 + NUM_BANKS - 1);
  localparam logic [ADDR_W-1:0] CLR_B0  = ADDR_W'(4 * 3 + NUM_BANKS - 1);
  localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(4 * GRP_COUNT);

  assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DIR_B0) |=> (pin_oe[BANK_W-1:0] == $past(bus_wdata)));

  assert_set_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SET_B0) |=>
      ((pin_out[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clear_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CLR_B0) |=>
      ((pin_out[BANK_W-1:0] & $past(bus_wdata)) == '0));

  assert_edge_needs_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_q & ~$past(edge_q))) |-> $past(|(pin_sync ^ pin_prev)));

  assert_irq_from_enabled_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(|(edge_hit & ie_q)));

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= MAP_END) |=> (bus_rdata == '0));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && $past(!bus_rd)) |-> $stable(bus_rdata));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/sim_gpio_edge_port.sv
`timescale 1ns/1ps
module sim_gpio_edge_port;
  localparam int NB = 3;
  localparam int BW = 8;
  localparam int NP = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [BW-1:0] bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [BW-1:0] bus_rdata;
  logic [NP-1:0] ext = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq_n;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_port #(.NUM_BANKS(NB), .BANK_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(ext), .pin_out(pin_out), .pin_oe(pin_oe), .irq_n(irq_n)
  );

  // behavioural reference state
  logic [NP-1:0] m_dir, m_out, m_re, m_fe, m_ie, m_ed, m_st;
  logic [NP-1:0] m_s1, m_s2, m_prev;
  logic [7:0]    m_rdata;
  logic [7:0]    m_rd_addr;
  bit            m_rd_pend;

  function automatic int bank_of(input logic [7:0] a);
    int g = int'(a) / 4;
    int k = int'(a) % 4;
    if (g < 9 && k < NB) return NB - 1 - k;   // R11: highest bank at offset 0
    return -1;
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] a);
    int bk = bank_of(a);
    logic [NP-1:0] src;
    if (bk < 0) return 8'h00;
    case (int'(a) / 4)
      0: src = m_s2;
      1: src = m_dir;
      4: src = m_re;
      5: src = m_fe;
      6: src = m_ie;
      7: src = m_ed;
      8: src = m_st;
      default: src = '0;
    endcase
    return 8'(src >> (8 * bk));
  endfunction

  function automatic string rtag(input logic [7:0] a);
    if (bank_of(a) < 0) return "R12";
    case (int'(a) / 4)
      0: return "R3/R11";
      1: return "R1/R11";
      4, 5: return "R5";
      7: return "R6/R8";
      8: return "R7/R8/R9";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [NP-1:0] hit, sthit, msk, val, eclr, sclr;
    int bk;
    if (!rst_n) begin
      m_dir = '0; m_out = '0; m_re = '0; m_fe = '0; m_ie = '0;
      m_ed = '0; m_st = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
      m_rdata = '0; m_rd_addr = '0; m_rd_pend = 1'b0;
    end else begin
      hit   = ((m_s2 & ~m_prev) & m_re) | ((~m_s2 & m_prev) & m_fe);
      sthit = hit & m_ie;
      eclr = '0; sclr = '0;
      m_rd_pend = bus_rd;
      if (bus_rd) begin
        m_rd_addr = bus_addr;
        m_rdata   = model_read(bus_addr);
      end
      bk = bank_of(bus_addr);
      if (bus_wr && bk >= 0) begin
        msk = NP'(8'hFF) << (8 * bk);
        val = NP'(bus_wdata) << (8 * bk);
        case (int'(bus_addr) / 4)
          1: m_dir = (m_dir & ~msk) | val;
          2: m_out = m_out | val;
          3: m_out = m_out & ~val;
          4: m_re  = (m_re & ~msk) | val;
          5: m_fe  = (m_fe & ~msk) | val;
          6: m_ie  = (m_ie & ~msk) | val;
          7: eclr  = val;
          8: sclr  = val;
          default: ;
        endcase
      end
      m_ed   = (m_ed & ~eclr) | hit;     // R9: event beats clear
      m_st   = (m_st & ~sclr) | sthit;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = ext;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pin_oe == m_dir, "R1", pin_oe, m_dir);
      chk(pin_out == m_out, "R2", pin_out, m_out);
      chk(irq_n == (m_st == '0), "R10", NP'(irq_n), NP'(m_st == '0));
      if (m_rd_pend)
        chk(bus_rdata == m_rdata, rtag(m_rd_addr), NP'(bus_rdata), NP'(m_rdata));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_all();
    for (int a = 0; a < 36; a++) rd(8'(a));
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state, every register zero
    read_all();

    // R1/R11: direction bytes, highest bank at offset 0
    wr(8'h04, 8'hA5); wr(8'h05, 8'h3C); wr(8'h06, 8'hFF);
    rd(8'h04); rd(8'h05); rd(8'h06);

    // R2: set and clear, zero bits leave pins alone
    wr(8'h0A, 8'h0F); wr(8'h0E, 8'h05); wr(8'h08, 8'h80);
    wr(8'h09, 8'hF0); wr(8'h0D, 8'h00); wr(8'h0C, 8'h80);
    rd(8'h08); rd(8'h0C);   // write-only groups read zero (R12)

    // R3/R11: monitor plus incrementing burst
    ext = 24'hC35A81;
    idle(3);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 8'h00;
    @(negedge clk); bus_addr = 8'h01;
    @(negedge clk); bus_addr = 8'h02;
    @(negedge clk); bus_rd = 1'b0;

    // R4/R5/R6/R7: bank0 rise, bank1 fall, bank2 both; irq only bank0
    wr(8'h12, 8'hFF); wr(8'h15, 8'hFF); wr(8'h10, 8'hFF); wr(8'h14, 8'hFF);
    wr(8'h1A, 8'hFF);
    ext = 24'h3CA57E;
    idle(4);
    read_all();
    ext = 24'h000000;
    idle(4);
    read_all();

    // R8: write-one-to-clear, zeros ignored
    wr(8'h22, 8'h0F); rd(8'h22);
    wr(8'h22, 8'h00); rd(8'h22);
    wr(8'h1E, 8'hFF); wr(8'h1D, 8'hFF); wr(8'h1C, 8'hFF);
    wr(8'h20, 8'hFF); wr(8'h21, 8'hFF); wr(8'h22, 8'hFF);
    read_all();

    // R9: pins toggling every cycle while clears land
    wr(8'h19, 8'hFF); wr(8'h18, 8'hFF);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      ext = ~ext;
      bus_addr = 8'(8'h1C + (i % 3) + ((i % 2) * 4));
      bus_wdata = 8'hFF; bus_wr = 1'b1;
    end
    @(negedge clk); bus_wr = 1'b0;
    read_all();

    // R12: unmapped addresses
    rd(8'h03); rd(8'h07); rd(8'h23); rd(8'h24); rd(8'h7F); rd(8'hFF);

    // mixed randomized traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      ext = ext ^ (NP'($urandom) & NP'($urandom) & NP'($urandom));
      case ($urandom % 4)
        0: begin bus_wr = 1'b1; bus_addr = 8'($urandom % 40); bus_wdata = 8'($urandom); end
        1: begin bus_rd = 1'b1; bus_addr = 8'($urandom % 40); end
        default: ;
      endcase
    end
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    idle(4);
    read_all();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule